// File: doc/BRIEF.md
# Dual Converter Start Controller

This block decides the cycle in which each of two analog-to-digital converter sequencers begins a conversion. It watches an asynchronous trigger pin, with a choice of which edge counts, and a per-converter software start request. It also tracks whether each converter is still converting, using the converter's busy and done handshake. Its outputs are one-cycle start pulses, one for each converter.

With paired operation switched off, each converter is handled on its own. A converter accepts a trigger only when the trigger pin is routed to it, or when it receives a software request, and only while it is idle. With paired operation switched on, any accepted request to either converter starts both of them in the same cycle. This is allowed only while the two converter configurations agree. If they disagree, the request is refused and a sticky error flag is raised, and software must clear that flag.

Top module: `adc_start_ctrl`

## Requirements
- R1: After reset both start outputs are 0 and `cfg_err` is 0.
- R2: With `edge_fall`=0, a rising edge on `trig_pin` gives a start pulse to every idle converter whose bit in `trig_route` is 1. The pulse appears three clock edges after the pin change is first sampled: two synchroniser stages plus the output register.
- R3: With `edge_fall`=1, only a falling edge on `trig_pin` triggers. An edge of the other polarity gives no start.
- R4: A converter is busy from its start pulse until its `done` pulse is sampled, and also whenever its `busy` input is 1. Pin edges that arrive while it is busy are dropped and are not remembered.
- R5: A one-cycle `sw_start[i]` pulse starts idle converter i in the next cycle. A software request made while converter i is busy is dropped.
- R6: Each start output is high for exactly one cycle per conversion.
- R7: With `dual_en`=1, a request to either converter, from the pin or from software, starts both converters in the same cycle, so that `start` is 2'b11.
- R8: With `dual_en`=1, the modes `mode_a` and `mode_b` must be equal. If they differ, a request produces no start and sets `cfg_err`.
- R9: A mode whose bit 1 is set is continuous. In paired operation with continuous modes, `chan_a` and `chan_b` must also be equal, or the request is refused and `cfg_err` is set. In non-continuous modes the two channel counts are ignored.
- R10: `cfg_err` stays at 1 until `err_clr` is pulsed. If a new error is raised in the same cycle as the clear, the flag stays set.
- R11: Pin-edge starts are accepted with any value of the mode inputs, including the continuous mode 2'b11.
- R12: With `dual_en`=1, a request made while either converter is busy is dropped for both converters and does not set `cfg_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_pin | input | 1 | Asynchronous external trigger pin |
| edge_fall | input | 1 | 0 = rising edge triggers, 1 = falling edge triggers |
| trig_route | input | 2 | Per-converter enable for pin triggering (bit 0 = A, bit 1 = B) |
| sw_start | input | 2 | Per-converter software start request |
| dual_en | input | 1 | Paired (simultaneous) start operation |
| mode_a | input | 2 | Operating mode of converter A (bit 1 = continuous) |
| mode_b | input | 2 | Operating mode of converter B |
| chan_a | input | 3 | Number of channels selected on converter A |
| chan_b | input | 3 | Number of channels selected on converter B |
| busy | input | 2 | Per-converter busy from the sequencer |
| done | input | 2 | Per-converter conversion-complete pulse |
| err_clr | input | 1 | Clears the configuration error flag |
| start | output | 2 | One-cycle start pulses |
| cfg_err | output | 1 | Sticky paired-configuration error |

## Verification
On every cycle, the assertions check four things. Start pulses last one cycle. No start follows a cycle in which that converter was busy. Paired operation only ever yields both starts or none. A configuration mismatch blocks every start, and the error flag keeps or loses its value only as the set and clear rules allow. The pin-to-start latency, the choice of edge polarity, and the fact that dropped edges are not remembered after the conversion ends can only be shown by the bench. It drives edges at chosen moments against a modelled converter and scores every start pulse against a queue of expected ones.

// File: rtl/adc_start_pkg.sv
package adc_start_pkg;
  localparam int MODE_W = 2;
  localparam int CHAN_W = 3;
  localparam int NCONV  = 2;

  typedef logic [MODE_W-1:0] mode_t;
  typedef logic [CHAN_W-1:0] chan_t;
  typedef logic [NCONV-1:0]  conv_vec_t;

  // Edge of the selected polarity between previous and current sample.
  function automatic logic edge_hit(input logic cur, input logic prev,
                                    input logic falling);
    return falling ? (prev & ~cur) : (cur & ~prev);
  endfunction

  // Continuous modes carry the top mode bit.
  function automatic logic is_continuous(input mode_t m);
    return m[MODE_W-1];
  endfunction

  // Paired start is legal when modes agree and, for continuous modes,
  // channel counts agree too.
  function automatic logic cfg_match(input mode_t ma, input mode_t mb,
                                     input chan_t ca, input chan_t cb);
    if (ma != mb) return 1'b0;
    if (is_continuous(ma)) return (ca == cb);
    return 1'b1;
  endfunction
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic falling,
  output logic hit
);
  import adc_start_pkg::*;

  logic [STAGES-1:0] chain;
  logic              prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= pin;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[STAGES-1];

  assign hit = edge_hit(chain[STAGES-1], prev, falling);
endmodule

// File: rtl/conv_tracker.sv
module conv_tracker #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] start,
  input  logic [N-1:0] busy,
  input  logic [N-1:0] done,
  output logic [N-1:0] blocked
);
  logic [N-1:0] active;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_conv
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)        active[g] <= 1'b0;
        else if (done[g])  active[g] <= 1'b0;
        else if (start[g]) active[g] <= 1'b1;

      assign blocked[g] = active[g] | busy[g] | start[g];
    end
  endgenerate
endmodule

// File: rtl/start_arbiter.sv
module start_arbiter
  import adc_start_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  conv_vec_t req,
  input  conv_vec_t blocked,
  input  logic      dual_en,
  input  logic      cfg_ok,
  input  logic      err_clr,
  output conv_vec_t start,
  output logic      cfg_err,
  output logic      err_set
);
  conv_vec_t start_n;
  logic      any_req, any_blk;

  assign any_req = |req;
  assign any_blk = |blocked;

  always_comb begin
    start_n = '0;
    err_set = 1'b0;
    if (dual_en) begin
      if (any_req && !any_blk) begin
        if (cfg_ok) start_n = '1;
        else        err_set = 1'b1;
      end
    end else begin
      start_n = req & ~blocked;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      start   <= '0;
      cfg_err <= 1'b0;
    end else begin
      start <= start_n;
      if (err_set)      cfg_err <= 1'b1;
      else if (err_clr) cfg_err <= 1'b0;
    end
endmodule

// File: rtl/adc_start_ctrl.sv
module adc_start_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_pin,
  input  logic       edge_fall,
  input  logic [1:0] trig_route,
  input  logic [1:0] sw_start,
  input  logic       dual_en,
  input  logic [1:0] mode_a,
  input  logic [1:0] mode_b,
  input  logic [2:0] chan_a,
  input  logic [2:0] chan_b,
  input  logic [1:0] busy,
  input  logic [1:0] done,
  input  logic       err_clr,
  output logic [1:0] start,
  output logic       cfg_err
);
  import adc_start_pkg::*;

  logic      pin_hit;
  conv_vec_t req;
  conv_vec_t blocked;
  logic      cfg_ok;
  logic      err_set;

  trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(trig_pin), .falling(edge_fall), .hit(pin_hit)
  );

  assign req    = ({NCONV{pin_hit}} & trig_route) | sw_start;
  assign cfg_ok = cfg_match(mode_a, mode_b, chan_a, chan_b);

  conv_tracker #(.N(NCONV)) u_track (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .blocked(blocked)
  );

  start_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .req(req), .blocked(blocked),
    .dual_en(dual_en), .cfg_ok(cfg_ok), .err_clr(err_clr),
    .start(start), .cfg_err(cfg_err), .err_set(err_set)
  );
endmodule

// File: rtl/adc_start_ctrl_chk.sv
module adc_start_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dual_en,
  input logic       err_clr,
  input logic [1:0] start,
  input logic [1:0] blocked,
  input logic       cfg_ok,
  input logic       err_set,
  input logic       cfg_err
);
  AST_START_A_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    start[0] |=> !start[0]); // R6
  AST_START_B_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    start[1] |=> !start[1]); // R6
  AST_A_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked[0] && !dual_en) |=> !start[0]); // R4
  AST_B_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked[1] && !dual_en) |=> !start[1]); // R5
  AST_DUAL_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    dual_en |=> (start == 2'b00 || start == 2'b11)); // R7
  AST_DUAL_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (dual_en && (|blocked)) |=> (start == 2'b00)); // R12
  AST_MISMATCH_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (dual_en && !cfg_ok) |=> (start == 2'b00)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !err_clr) |=> cfg_err); // R10
  AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !err_set) |=> !cfg_err); // R10
  AST_ERR_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> cfg_err); // R8
endmodule

bind adc_start_ctrl adc_start_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dual_en(dual_en), .err_clr(err_clr),
  .start(start), .blocked(blocked), .cfg_ok(cfg_ok), .err_set(err_set),
  .cfg_err(cfg_err)
);

// File: tb/adc_start_ctrl_tb.sv
module adc_start_ctrl_tb;
  localparam int LAT = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trig_pin = 1'b0, edge_fall = 1'b0, dual_en = 1'b0, err_clr = 1'b0;
  logic [1:0] trig_route = 2'b00, sw_start = 2'b00;
  logic [1:0] mode_a = 2'b00, mode_b = 2'b00;
  logic [2:0] chan_a = 3'd1, chan_b = 3'd1;
  logic       busy0 = 1'b0, busy1 = 1'b0, done0 = 1'b0, done1 = 1'b0;
  logic [1:0] start;
  logic       cfg_err;
  logic       finished = 1'b0;

  always #2 clk = ~clk;

  adc_start_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .trig_pin(trig_pin), .edge_fall(edge_fall),
    .trig_route(trig_route), .sw_start(sw_start), .dual_en(dual_en),
    .mode_a(mode_a), .mode_b(mode_b), .chan_a(chan_a), .chan_b(chan_b),
    .busy({busy1, busy0}), .done({done1, done0}), .err_clr(err_clr),
    .start(start), .cfg_err(cfg_err)
  );

  typedef struct { logic [1:0] v; string tag; } exp_t;
  exp_t exp_q[$];
  int n_cmp = 0, n_bad = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_start(input logic [1:0] v, input string tag);
    exp_t e;
    e.v = v; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drained(input string tag);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic sw_pulse(input logic [1:0] v);
    sw_start = v; cycles(1); sw_start = 2'b00;
  endtask

  task automatic err_clear();
    err_clr = 1'b1; cycles(1); err_clr = 1'b0;
  endtask

  // Converter models
  initial forever begin
    @(negedge clk);
    if (start[0]) begin
      busy0 = 1'b1; cycles(LAT); busy0 = 1'b0; done0 = 1'b1; cycles(1); done0 = 1'b0;
    end
  end
  initial forever begin
    @(negedge clk);
    if (start[1]) begin
      busy1 = 1'b1; cycles(LAT); busy1 = 1'b0; done1 = 1'b1; cycles(1); done1 = 1'b0;
    end
  end

  // Scoreboard monitor
  initial begin
    logic [1:0] prev;
    prev = 2'b00;
    forever begin
      @(negedge clk);
      if (rst_n && !finished) begin
        if (start != 2'b00) begin
          if (prev != 2'b00) check(1'b0, "R6 start held two cycles", start, 0);
          if (exp_q.size() == 0) check(1'b0, "R4/R12 unexpected start", start, 0);
          else begin
            exp_t e;
            e = exp_q.pop_front();
            check(start == e.v, e.tag, start, e.v);
          end
        end
        prev = start;
      end
    end
  end

  initial begin
    cycles(60000);
    check(1'b0, "watchdog expired", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    cycles(3);
    check(start == 2'b00, "R1 start after reset", start, 0);
    check(cfg_err == 1'b0, "R1 cfg_err after reset", cfg_err, 0);
    rst_n = 1'b1;
    cycles(2);

    // R2: rising edge, exact latency
    trig_route = 2'b01;
    trig_pin = 1'b1;
    cycles(2);
    check(start == 2'b00, "R2 no start before third edge", start, 0);
    expect_start(2'b01, "R2 rising edge start A");
    cycles(20);
    drained("R2 drained");

    // R3: falling edge ignored with rising polarity
    trig_pin = 1'b0; cycles(20);
    drained("R3 falling ignored when rising selected");

    // R3: falling polarity
    edge_fall = 1'b1; cycles(2);
    trig_pin = 1'b1; cycles(6);
    drained("R3 rising ignored when falling selected");
    expect_start(2'b01, "R3 falling edge start A");
    trig_pin = 1'b0;
    // R4: edges during conversion dropped
    cycles(4);
    trig_pin = 1'b1; cycles(2);
    trig_pin = 1'b0; cycles(30);
    drained("R4 edges during busy dropped");

    // R5: software start on B, second request while busy dropped
    expect_start(2'b10, "R5 software start B");
    sw_pulse(2'b10);
    cycles(4);
    sw_pulse(2'b10);
    cycles(25);
    drained("R5 software request while busy dropped");

    // R11: edge trigger in continuous mode
    mode_a = 2'b11; mode_b = 2'b11; edge_fall = 1'b0;
    expect_start(2'b01, "R11 edge start in mode 3");
    trig_pin = 1'b1; cycles(25);
    drained("R11 drained");
    trig_pin = 1'b0; cycles(5);

    // R7 + R9: dual, non-continuous, differing channel counts
    mode_a = 2'b00; mode_b = 2'b00; chan_a = 3'd2; chan_b = 3'd5;
    dual_en = 1'b1; trig_route = 2'b00;
    expect_start(2'b11, "R7 sw B starts both (R9 counts ignored)");
    sw_pulse(2'b10);
    // R12: request while busy in dual mode dropped
    cycles(4);
    sw_pulse(2'b01);
    cycles(25);
    drained("R12 dual request while busy dropped");
    check(cfg_err == 1'b0, "R12 no error on dropped request", cfg_err, 0);

    // R7: pin trigger routed to A starts both
    trig_route = 2'b01;
    expect_start(2'b11, "R7 pin trigger starts both");
    trig_pin = 1'b1; cycles(25);
    drained("R7 drained");
    trig_pin = 1'b0; cycles(5);
    trig_route = 2'b00;

    // R8: mode mismatch
    mode_b = 2'b01;
    sw_pulse(2'b01);
    cycles(2);
    check(cfg_err == 1'b1, "R8 mismatch sets cfg_err", cfg_err, 1);
    drained("R8 mismatch gives no start");

    // R10: sticky, then cleared
    cycles(8);
    check(cfg_err == 1'b1, "R10 cfg_err sticky", cfg_err, 1);
    err_clear(); cycles(1);
    check(cfg_err == 1'b0, "R10 cfg_err cleared", cfg_err, 0);

    // R10: set wins over clear in same cycle
    sw_start = 2'b01; err_clr = 1'b1; cycles(1);
    sw_start = 2'b00; err_clr = 1'b0; cycles(1);
    check(cfg_err == 1'b1, "R10 set wins over clear", cfg_err, 1);
    err_clear(); cycles(1);

    // R9: continuous, unequal counts refused
    mode_a = 2'b10; mode_b = 2'b10;
    sw_pulse(2'b10);
    cycles(3);
    check(cfg_err == 1'b1, "R9 continuous count mismatch sets cfg_err", cfg_err, 1);
    drained("R9 continuous mismatch gives no start");
    err_clear();
    chan_b = 3'd2;
    expect_start(2'b11, "R9 continuous equal counts start both");
    sw_pulse(2'b10);
    cycles(25);
    drained("R9 drained");
    check(cfg_err == 1'b0, "R9 no error when counts equal", cfg_err, 0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule